// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the target side of a byte-addressed serial EEPROM on a two-wire bus, built so that it can be synthesized. It samples the open-drain clock and data lines with the system clock and finds start, stop and repeated-start conditions. It accepts a device address byte and answers only when that byte carries the fixed device tag and the two strap-selected select bits. It then takes a two-byte word address and either stores the data bytes that follow or returns bytes from the array. A host can read from the current address, from an address it loads first, or as a continuing stream.

Once a write is closed by a stop condition, the block behaves like a device running its internal program cycle. For a fixed number of system clock cycles it ignores the bus completely and does not acknowledge its own address. The host uses this to poll for completion. A protect input blocks every change to the array. The array depth and the page size are parameters: ADDR_W = 14 gives the full 16,384-byte array, and the default is kept smaller so that it elaborates quickly. The bus is driven only by pulling data low through `sda_oe_o`.

Top module: `eeprom_target`

## Requirements
- R1: A device address byte is accepted only if bits 7..4 are 1010, bit 3 is 0 and bits 2..1 equal `sel_i`. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. On a match the block pulls SDA low during the ninth clock.
- R2: A device address byte that does not match gets no acknowledge. The block then leaves SDA released for every later byte until the next start condition.
- R3: In a write, the two word-address bytes (high byte first) and every data byte are each acknowledged. A data byte is stored at the address formed by the low ADDR_W bits of the 16-bit word address, and the upper bits are ignored.
- R4: After each stored byte, only the low PAGE_W address bits increment, and they wrap to the start of the same page. The upper bits keep their value.
- R5: A stop that follows at least one stored byte starts a busy window of WRITE_CYC system clocks. During that window start conditions are ignored, no device address is acknowledged and the block never drives SDA.
- R6: After the busy window ends, a start followed by a matching device address is acknowledged again.
- R7: While `wp_i` is high, data bytes are still acknowledged but the array is not changed. The closing stop starts no busy window.
- R8: A current-address read returns the byte at the internal address counter. The counter always points one past the last byte written or read.
- R9: A random read is a write header carrying only the word address, then a repeated start and a read device address. It returns data starting at the loaded address.
- R10: A read continues byte after byte while the host acknowledges. The address counter wraps from the top of the whole array to 0 and is not confined to a page.
- R11: When the host does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R12: Start (SDA falling while SCL is high) and stop (SDA rising while SCL is high) are detected after a two-flop synchronizer on each line. A repeated start at any point restarts the device-address phase. The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel_i | input | 2 | Strapped device-select value |
| wp_i | input | 1 | 1 protects the whole array from writes |

## Verification
The hardest situation to reach from the ports is a start condition that arrives while the busy window is still running. The host has to begin its poll at a known point after the stop, inside WRITE_CYC clocks. The bench does this with polls at two delays after a stop: one right after it and one near the end of the window. Both must go unacknowledged, and a later poll must be acknowledged. A second hard case is a host no-acknowledge with no stop after it. The bench keeps clocking with SDA released and checks every sampled bit for a pull-down.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } tgt_state_e;

    // fixed upper five bits of the device address byte: tag 1010 then 0
    localparam logic [4:0] DEV_TAG = 5'b10100;

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] m1_q, m2_q, prev_q;

    assign raw = {scl_i, sda_i};

    // one synchronizer plus history flop per line (R12)
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m1_q[g]   <= 1'b1;
                m2_q[g]   <= 1'b1;
                prev_q[g] <= 1'b1;
            end else begin
                m1_q[g]   <= raw[g];
                m2_q[g]   <= m1_q[g];
                prev_q[g] <= m2_q[g];
            end
        end
    end

    assign scl_o      = m2_q[1];
    assign sda_o      = m2_q[0];
    assign scl_rise_o = m2_q[1] & ~prev_q[1];
    assign scl_fall_o = ~m2_q[1] & prev_q[1];
    assign start_o    = m2_q[1] & prev_q[1] & prev_q[0] & ~m2_q[0];
    assign stop_o     = m2_q[1] & prev_q[1] & ~prev_q[0] & m2_q[0];

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eeprom_tgt_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 6,
    parameter int WRITE_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] sel_i,
    input  logic       wp_i
);
    localparam int BUSY_W = $clog2(WRITE_CYC + 1);

    typedef struct packed {
        tgt_state_e          st;
        logic [3:0]          cnt;
        logic                ack;
        logic [7:0]          sh;
        logic                drv;
        logic                rw;
        logic                nack;
        logic [7:0]          ahi;
        logic [ADDR_W-1:0]   addr;
        logic                wpend;
        logic [BUSY_W-1:0]   busy;
    } regs_t;

    regs_t r_q, r_d;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic mem_we;
    logic [7:0] mem_rd;
    logic in_idle;
    logic [BUSY_W-1:0] busy_left;

    eeprom_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    eeprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (r_q.addr),
        .wdata_i (r_q.sh),
        .raddr_i (r_q.addr),
        .rdata_o (mem_rd)
    );

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (r_q.busy != '0) r_d.busy = r_q.busy - BUSY_W'(1);

        if (bus_stop) begin
            r_d.st  = ST_IDLE;
            r_d.drv = 1'b0;
            r_d.ack = 1'b0;
            if (r_q.wpend) begin
                r_d.busy  = BUSY_W'(WRITE_CYC);
                r_d.wpend = 1'b0;
            end
        end else if (bus_start) begin
            r_d.drv = 1'b0;
            r_d.ack = 1'b0;
            r_d.cnt = '0;
            r_d.st  = (r_q.busy != '0) ? ST_IDLE : ST_DEV;
        end else begin
            case (r_q.st)
                ST_IDLE: ;
                ST_RD: begin
                    if (!r_q.ack) begin
                        if (scl_rise) begin
                            r_d.cnt = r_q.cnt + 4'd1;
                        end else if (scl_fall && r_q.cnt != '0) begin
                            if (r_q.cnt == 4'd8) begin
                                r_d.drv = 1'b0;
                                r_d.ack = 1'b1;
                            end else begin
                                r_d.sh  = {r_q.sh[6:0], 1'b0};
                                r_d.drv = ~r_q.sh[6];
                            end
                        end
                    end else if (scl_rise) begin
                        r_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (r_q.nack) begin
                            r_d.st  = ST_IDLE;
                            r_d.ack = 1'b0;
                        end else begin
                            r_d.sh   = mem_rd;
                            r_d.drv  = ~mem_rd[7];
                            r_d.addr = r_q.addr + ADDR_W'(1);
                            r_d.cnt  = '0;
                            r_d.ack  = 1'b0;
                        end
                    end
                end
                default: begin
                    if (!r_q.ack) begin
                        if (scl_rise && r_q.cnt != 4'd8) begin
                            r_d.sh  = {r_q.sh[6:0], sda_s};
                            r_d.cnt = r_q.cnt + 4'd1;
                        end else if (scl_fall && r_q.cnt == 4'd8) begin
                            r_d.ack = 1'b1;
                            r_d.drv = 1'b1;
                            case (r_q.st)
                                ST_DEV: begin
                                    if (r_q.sh[7:3] == DEV_TAG && r_q.sh[2:1] == sel_i) begin
                                        r_d.rw = r_q.sh[0];
                                    end else begin
                                        r_d.st  = ST_IDLE;
                                        r_d.ack = 1'b0;
                                        r_d.drv = 1'b0;
                                    end
                                end
                                ST_AHI: r_d.ahi  = r_q.sh;
                                ST_ALO: r_d.addr = ADDR_W'({r_q.ahi, r_q.sh});
                                default: begin
                                    if (!wp_i) begin
                                        mem_we    = 1'b1;
                                        r_d.wpend = 1'b1;
                                    end
                                    r_d.addr = {r_q.addr[ADDR_W-1:PAGE_W],
                                                r_q.addr[PAGE_W-1:0] + PAGE_W'(1)};
                                end
                            endcase
                        end
                    end else if (scl_fall) begin
                        r_d.ack = 1'b0;
                        r_d.drv = 1'b0;
                        r_d.cnt = '0;
                        case (r_q.st)
                            ST_DEV: begin
                                if (r_q.rw) begin
                                    r_d.st   = ST_RD;
                                    r_d.sh   = mem_rd;
                                    r_d.drv  = ~mem_rd[7];
                                    r_d.addr = r_q.addr + ADDR_W'(1);
                                end else begin
                                    r_d.st = ST_AHI;
                                end
                            end
                            ST_AHI:  r_d.st = ST_ALO;
                            ST_ALO:  r_d.st = ST_WR;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o  = r_q.drv;
    assign in_idle   = (r_q.st == ST_IDLE);
    assign busy_left = r_q.busy;

endmodule

// File: rtl/eeprom_target_chk.sv
module eeprom_target_chk #(
    parameter int BUSY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              in_idle,
    input logic [BUSY_W-1:0] busy_left,
    input logic              mem_we
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_oe);                                        // R11
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_left != '0) |-> !sda_oe);                              // R5
    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_left != '0) |=> (busy_left == $past(busy_left) - 1'b1)); // R5
    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy_left == '0));                               // R5
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);                                // R12
endmodule

bind eeprom_target eeprom_target_chk #(.BUSY_W(BUSY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_s     (scl_s),
    .in_idle   (in_idle),
    .busy_left (busy_left),
    .mem_we    (mem_we)
);

// File: tb/tb_eeprom_target.sv
`timescale 1ns/1ps
module tb_eeprom_target;
    localparam int AW = 11;
    localparam int PW = 6;
    localparam int WC = 200;
    localparam int H  = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic [1:0] sel = 2'b10;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_h & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYC(WC)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .sel_i    (sel),
        .wp_i     (wp)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] ref_mem [DEPTH];
    int ref_ptr = 0;
    bit quiet = 1'b0;
    int quiet_err = 0;
    logic [7:0] wbuf [4];

    // per-clock comparison: the model says the target must be silent
    always @(negedge clk) if (rst_n && quiet && sda_oe) quiet_err++;

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_h = 1'b1; wt(H);
        scl_h = 1'b1; wt(H);
        sda_h = 1'b0; wt(H);
        scl_h = 1'b0; wt(H);
    endtask

    task automatic bstop();
        sda_h = 1'b0; wt(H);
        scl_h = 1'b1; wt(H);
        sda_h = 1'b1; wt(H);
    endtask

    task automatic put_bit(bit b);
        sda_h = b; wt(H);
        scl_h = 1'b1; wt(H);
        scl_h = 1'b0; wt(2);
    endtask

    task automatic get_bit(output bit b);
        sda_h = 1'b1; wt(H);
        scl_h = 1'b1; wt(H/2);
        b = sda_line; wt(H/2);
        scl_h = 1'b0; wt(2);
    endtask

    task automatic put_byte(logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit host_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!host_ack);
    endtask

    function automatic logic [7:0] devb(logic [1:0] s, bit rd);
        return {4'b1010, 1'b0, s, rd};
    endfunction

    function automatic int page_next(int p);
        return (p & ~((1 << PW) - 1)) | ((p + 1) & ((1 << PW) - 1));
    endfunction

    task automatic wr_txn(logic [15:0] a, int n, string req);
        bit ak;
        int p;
        bstart();
        put_byte(devb(sel, 1'b0), ak); check("R1", "write device address ack", ak, 1);
        put_byte(a[15:8], ak);         check("R3", "word address high ack", ak, 1);
        put_byte(a[7:0], ak);          check("R3", "word address low ack", ak, 1);
        p = int'(a) & (DEPTH - 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], ak);
            check(req, "data byte ack", ak, 1);
            if (!wp) ref_mem[p] = wbuf[i];
            p = page_next(p);
        end
        ref_ptr = p;
        bstop();
    endtask

    task automatic poll(bit exp_ack, string req);
        bit ak;
        bstart();
        put_byte(devb(sel, 1'b0), ak);
        check(req, "poll acknowledge", ak, exp_ack);
        bstop();
    endtask

    task automatic finish_write(int gap);
        quiet = 1'b1;
        wt(gap);
        poll(1'b0, "R5");
        wt(WC);
        quiet = 1'b0;
        check("R5", "no drive while busy", quiet_err, 0);
        poll(1'b1, "R6");
    endtask

    task automatic rd_bytes(int n, string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            get_byte(v, i != n - 1);
            check(req, "read data", v, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
    endtask

    task automatic rd_random(logic [15:0] a, int n, string req, bit do_stop);
        bit ak;
        bstart();
        put_byte(devb(sel, 1'b0), ak); check("R9", "header ack", ak, 1);
        put_byte(a[15:8], ak);         check("R9", "address high ack", ak, 1);
        put_byte(a[7:0], ak);          check("R9", "address low ack", ak, 1);
        bstart();
        put_byte(devb(sel, 1'b1), ak); check("R12", "repeated start read ack", ak, 1);
        ref_ptr = int'(a) & (DEPTH - 1);
        rd_bytes(n, req);
        if (do_stop) bstop();
    endtask

    task automatic rd_current(int n, string req);
        bit ak;
        bstart();
        put_byte(devb(sel, 1'b1), ak); check("R8", "current read ack", ak, 1);
        rd_bytes(n, req);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ak;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        check("R12", "reset drive state", sda_oe, 0);

        // select mismatch and following bytes ignored
        quiet = 1'b1;
        bstart();
        put_byte(devb(2'b01, 1'b0), ak); check("R2", "wrong select ack", ak, 0);
        put_byte(8'h00, ak);             check("R2", "byte after mismatch", ak, 0);
        bstop();
        bstart();
        put_byte(8'b1011_0100, ak);      check("R1", "wrong tag ack", ak, 0);
        bstop();
        bstart();
        put_byte(8'b1010_1100, ak);      check("R1", "bit3 set ack", ak, 0);
        bstop();
        quiet = 1'b0;
        check("R2", "no drive after mismatch", quiet_err, 0);

        // basic write, polling right after stop
        wbuf = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_txn(16'h0010, 4, "R3");
        finish_write(0);

        // random then current reads
        rd_random(16'h0010, 2, "R9", 1'b1);
        rd_current(1, "R8");
        rd_current(1, "R8");

        // page wrap
        wbuf = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
        wr_txn(16'h007E, 4, "R4");
        finish_write(140);
        rd_random(16'h007E, 2, "R4", 1'b1);
        rd_random(16'h0040, 2, "R4", 1'b1);

        // upper word-address bits ignored
        wbuf[0] = 8'h5A;
        wr_txn(16'hF805, 1, "R3");
        finish_write(0);
        rd_random(16'h0005, 1, "R3", 1'b1);

        // protected write
        wp = 1'b1;
        wbuf[0] = 8'hEE;
        wbuf[1] = 8'hEF;
        wr_txn(16'h0010, 2, "R7");
        poll(1'b1, "R7");
        wp = 1'b0;
        rd_random(16'h0010, 2, "R7", 1'b1);

        // wrap at top of array
        wbuf[0] = 8'h77;
        wr_txn(16'h07FF, 1, "R3");
        finish_write(0);
        wbuf[0] = 8'h88;
        wr_txn(16'h0000, 1, "R3");
        finish_write(0);
        rd_random(16'h07FF, 2, "R10", 1'b1);

        // host nack ends read
        rd_random(16'h0010, 1, "R11", 1'b0);
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bit b;
            get_bit(b);
            check("R11", "line after nack", b, 1);
        end
        bstop();
        quiet = 1'b0;
        check("R11", "no drive after nack", quiet_err, 0);
        rd_current(1, "R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule